// File: doc/BRIEF.md
# Protection Status Latch and Interrupt Controller

This block watches the protection comparators of a supply regulator that feeds power down a coaxial cable, and from them it builds an eight-bit status byte, gates the internal output enable, and drives an active-low interrupt request. Overcurrent, overtemperature and supply undervoltage are sticky fault bits. A fault bit can only be cleared on the ninth clock of a host read, and only if the fault has gone away. The "power not good" bit follows the output voltage window with hysteresis and is not latched.

An overcurrent disable timer counts millisecond ticks while the overcurrent comparator is high. The timer shuts the output off after a sustained overload. Any fault holds the output off until the host writes the enable bit again after the fault is gone. The interrupt line goes low when a fault bit newly latches, and also at power-on. It is released only when the host addresses the block for a read.

Top module: `lnb_fault_status`

## Requirements
- R1: After reset the status byte is 0x81 (disabled bit and undervoltage bit set), `irq_n` is 0 and `out_en` is 0.
- R2: Status byte bit positions are fixed: bit 0 disabled, bit 2 overcurrent, bit 4 power not good, bit 6 overtemperature, bit 7 undervoltage. Bits 1, 3 and 5 read 0. A value of 0x00 means enabled and healthy.
- R3: The overcurrent bit latches on the OC_MS-th consecutive clock in which `oc_flag` and `tick_1ms` are both high (48 by default). A cycle with `oc_flag` low resets the count to zero.
- R4: `ot_flag` sets the overtemperature bit and `uv_flag` sets the undervoltage bit. A latched fault bit clears on an `rd_ack9` pulse only if its raw flag is low in that cycle. If the raw flag is still high, the bit stays set, and setting wins over clearing.
- R5: Any newly latched fault sets the disabled bit and forces `out_en` low.
- R6: `out_en` is high only while `en_bit` is 1 and the disabled bit is 0. A `wr_done` pulse with `en_bit`=1 and no fault latched clears the disabled bit. A `wr_done` with `en_bit`=0, or one made while a fault is latched, leaves the disabled bit set.
- R7: The power-not-good bit sets while `out_en` is high and `below_lo` is 1. It clears when `above_hi` is 1 with `below_lo` 0, holds otherwise, and is forced to 0 while `out_en` is low.
- R8: `irq_n` goes to 0 one cycle after a fault bit newly latches. Changes of the disabled or power-not-good bits never pull it low.
- R9: An `rd_addr` pulse releases `irq_n` to 1 unless a new fault latches in the same cycle. An `rd_ack9` pulse alone does not release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_flag | input | 1 | Raw overcurrent comparator |
| ot_flag | input | 1 | Raw overtemperature comparator |
| uv_flag | input | 1 | Raw supply undervoltage comparator |
| below_lo | input | 1 | Output voltage below 85 % of target |
| above_hi | input | 1 | Output voltage above 90 % of target |
| en_bit | input | 1 | Output-enable control bit from the register block |
| wr_done | input | 1 | One-cycle pulse at the end of a host write |
| rd_addr | input | 1 | One-cycle pulse when the block is addressed for a read |
| rd_ack9 | input | 1 | One-cycle pulse at the ninth clock of a data read |
| tick_1ms | input | 1 | One-cycle millisecond tick |
| status | output | 8 | Status register 1 |
| out_en | output | 1 | Gated internal output enable |
| irq_n | output | 1 | Interrupt request, 0 pulls the shared line low |

## Verification
A wrong overcurrent count shows up at the ports as an overcurrent bit that appears one cycle early or late after the 48th qualifying cycle, or that appears after an interrupted run that should have restarted the count. A wrong latch or disable state shows up within one clock: in the status byte, as `out_en` staying high after a fault, or as `out_en` coming back on after a write made while a fault is latched. A wrong interrupt state shows up one cycle after a fault edge or a read-address pulse. The bench's per-clock reference model therefore catches every divergence in the cycle it happens.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  localparam int unsigned ST_W    = 8;
  localparam int unsigned B_DIS   = 0;
  localparam int unsigned B_OCP   = 2;
  localparam int unsigned B_PNG   = 4;
  localparam int unsigned B_TSD   = 6;
  localparam int unsigned B_VUV   = 7;
  localparam int unsigned N_FAULT = 3;
  // fault vector index order
  localparam int unsigned F_OC = 0;
  localparam int unsigned F_OT = 1;
  localparam int unsigned F_UV = 2;
  typedef logic [N_FAULT-1:0] fault_vec_t;
endpackage

// File: rtl/lfs_oc_timer.sv
module lfs_oc_timer #(
  parameter int unsigned OC_MS = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_flag,
  input  logic tick,
  output logic trip
);
  localparam int unsigned CW = (OC_MS > 1) ? $clog2(OC_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OC_MS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    trip   = oc_flag && tick && (cnt_q == LAST);
    cnt_en = !oc_flag || tick;
    if (!oc_flag || trip) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lfs_fault_latch.sv
module lfs_fault_latch #(
  parameter int unsigned N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] cond,
  input  logic         clr,
  output logic [N-1:0] q,
  output logic [N-1:0] q_next,
  output logic [N-1:0] rise
);
  logic [N-1:0] q_r;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      if (set[i])                q_next[i] = 1'b1;
      else if (clr && !cond[i])  q_next[i] = 1'b0;
      else                       q_next[i] = q_r[i];
      rise[i] = set[i] && !q_r[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r[i] <= RST_VAL[i];
      else        q_r[i] <= q_next[i];
    end
  end

  assign q = q_r;
endmodule

// File: rtl/lfs_png_hyst.sv
module lfs_png_hyst (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic below_lo,
  input  logic above_hi,
  output logic png
);
  logic png_q, png_d;

  always_comb begin
    if (!active)       png_d = 1'b0;
    else if (below_lo) png_d = 1'b1;
    else if (above_hi) png_d = 1'b0;
    else               png_d = png_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) png_q <= 1'b0;
    else        png_q <= png_d;
  end

  assign png = png_q;
endmodule

// File: rtl/lnb_fault_status.sv
module lnb_fault_status
  import lfs_pkg::*;
#(
  parameter int unsigned OC_MS = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            oc_flag,
  input  logic            ot_flag,
  input  logic            uv_flag,
  input  logic            below_lo,
  input  logic            above_hi,
  input  logic            en_bit,
  input  logic            wr_done,
  input  logic            rd_addr,
  input  logic            rd_ack9,
  input  logic            tick_1ms,
  output logic [ST_W-1:0] status,
  output logic            out_en,
  output logic            irq_n
);
  localparam fault_vec_t FAULT_RST = fault_vec_t'(1) << F_UV;

  logic       oc_trip;
  fault_vec_t f_set, f_cond, f_q, f_next, f_rise;
  logic       any_next, any_rise, png;
  logic       dis_q, dis_d, irq_q, irq_d;

  lfs_oc_timer #(.OC_MS(OC_MS)) u_timer (
    .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .tick(tick_1ms), .trip(oc_trip)
  );

  always_comb begin
    f_set        = '0;
    f_set[F_OC]  = oc_trip;
    f_set[F_OT]  = ot_flag;
    f_set[F_UV]  = uv_flag;
    f_cond       = '0;
    f_cond[F_OC] = oc_flag;
    f_cond[F_OT] = ot_flag;
    f_cond[F_UV] = uv_flag;
  end

  lfs_fault_latch #(.N(N_FAULT), .RST_VAL(FAULT_RST)) u_latch (
    .clk(clk), .rst_n(rst_n), .set(f_set), .cond(f_cond), .clr(rd_ack9),
    .q(f_q), .q_next(f_next), .rise(f_rise)
  );

  assign out_en = en_bit && !dis_q;

  lfs_png_hyst u_png (
    .clk(clk), .rst_n(rst_n), .active(out_en),
    .below_lo(below_lo), .above_hi(above_hi), .png(png)
  );

  always_comb begin
    any_next = |f_next;
    any_rise = |f_rise;
    if (wr_done)       dis_d = !(en_bit && !any_next);
    else if (any_rise) dis_d = 1'b1;
    else               dis_d = dis_q;
    if (any_rise)      irq_d = 1'b1;
    else if (rd_addr)  irq_d = 1'b0;
    else               irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= 1'b1;
      irq_q <= 1'b1;
    end else begin
      dis_q <= dis_d;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    status        = '0;
    status[B_DIS] = dis_q;
    status[B_OCP] = f_q[F_OC];
    status[B_PNG] = png;
    status[B_TSD] = f_q[F_OT];
    status[B_VUV] = f_q[F_UV];
  end

  assign irq_n = !irq_q;
endmodule

// File: rtl/lfs_checker.sv
module lfs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       oc_flag,
  input logic       ot_flag,
  input logic       uv_flag,
  input logic       en_bit,
  input logic       rd_addr,
  input logic       rd_ack9,
  input logic       tick_1ms,
  input logic [7:0] status,
  input logic       out_en,
  input logic       irq_n
);
  logic any_fault;
  assign any_fault = status[2] || status[6] || status[7];

  // R3: overcurrent bit only rises on a qualifying tick
  p_trip_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> ($past(oc_flag) && $past(tick_1ms)));

  // R4: a persisting undervoltage survives the read clear
  p_hold_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack9 && uv_flag) |=> status[7]);

  // R5: a latched fault always shows the disabled bit
  p_fault_dis_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_fault |-> status[0]);

  // R6: output never on with a fault latched or enable bit low
  p_outen_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (!any_fault && en_bit));

  // R7: power-not-good cleared while the output is off
  p_png_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> !status[4]);

  // R8: new overtemperature pulls the interrupt low
  p_irq_tsd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> !irq_n);

  // R9: read addressing with no fault flag raised releases the line
  p_irq_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr && !oc_flag && !ot_flag && !uv_flag) |=> irq_n);
endmodule

bind lnb_fault_status lfs_checker u_lfs_checker (
  .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .ot_flag(ot_flag),
  .uv_flag(uv_flag), .en_bit(en_bit), .rd_addr(rd_addr), .rd_ack9(rd_ack9),
  .tick_1ms(tick_1ms), .status(status), .out_en(out_en), .irq_n(irq_n)
);

// File: tb/test_lnb_fault_status.sv
`timescale 1ns/1ps
module test_lnb_fault_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oc_flag = 0, ot_flag = 0, uv_flag = 0, below_lo = 0, above_hi = 0;
  logic en_bit = 0, wr_done = 0, rd_addr = 0, rd_ack9 = 0, tick_1ms = 1;
  logic [7:0] status;
  logic out_en, irq_n;

  int n_tests = 0, n_fail = 0, n_cyc = 0;

  always #10 clk = ~clk;

  lnb_fault_status i_lnb_fault_status (
    .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .ot_flag(ot_flag),
    .uv_flag(uv_flag), .below_lo(below_lo), .above_hi(above_hi),
    .en_bit(en_bit), .wr_done(wr_done), .rd_addr(rd_addr), .rd_ack9(rd_ack9),
    .tick_1ms(tick_1ms), .status(status), .out_en(out_en), .irq_n(irq_n)
  );

  // behavioural reference model
  int m_cnt;
  bit m_ocp, m_tsd, m_vuv, m_dis, m_png, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ocp = 0; m_tsd = 0; m_vuv = 1;
      m_dis = 1; m_png = 0; m_irq = 1;
    end else begin
      bit trip, nw, o_n, t_n, v_n, on_now;
      trip = oc_flag && tick_1ms && (m_cnt == 47);
      if (!oc_flag || trip) m_cnt = 0;
      else if (tick_1ms)    m_cnt = m_cnt + 1;
      nw = (trip && !m_ocp) || (ot_flag && !m_tsd) || (uv_flag && !m_vuv);
      o_n = trip    ? 1'b1 : (rd_ack9 && !oc_flag) ? 1'b0 : m_ocp;
      t_n = ot_flag ? 1'b1 : (rd_ack9 && !ot_flag) ? 1'b0 : m_tsd;
      v_n = uv_flag ? 1'b1 : (rd_ack9 && !uv_flag) ? 1'b0 : m_vuv;
      on_now = en_bit && !m_dis;
      if (!on_now)       m_png = 0;
      else if (below_lo) m_png = 1;
      else if (above_hi) m_png = 0;
      if (wr_done)  m_dis = !(en_bit && !(o_n || t_n || v_n));
      else if (nw)  m_dis = 1;
      if (nw)           m_irq = 1;
      else if (rd_addr) m_irq = 0;
      m_ocp = o_n; m_tsd = t_n; m_vuv = v_n;
    end
  end

  function automatic logic [7:0] model_status();
    return {m_vuv, m_tsd, 1'b0, m_png, 1'b0, m_ocp, 1'b0, m_dis};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-clock comparison, inputs stable here
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4/R6/R7 status vs model", status, model_status());
      chk("R6 out_en vs model", out_en, en_bit && !m_dis);
      chk("R8 irq_n vs model", irq_n, !m_irq);
    end
  end

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #3;
    end
  endtask

  task automatic pulse_wr(bit en);
    en_bit = en; wr_done = 1; step(); wr_done = 0;
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 100000) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=%0d expected<100000", n_cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step(2); rst_n = 1; step();
    chk("R1 reset status", status, 8'h81);
    chk("R1 reset irq_n", irq_n, 0);
    chk("R1 reset out_en", out_en, 0);

    rd_ack9 = 1; step(); rd_ack9 = 0;
    chk("R9 ack9 alone keeps irq", irq_n, 0);
    chk("R4 undervoltage cleared", status, 8'h01);
    rd_addr = 1; step(); rd_addr = 0;
    chk("R9 read addressing releases irq", irq_n, 1);
    pulse_wr(1);
    chk("R6 enable write clears DIS", status, 8'h00);
    chk("R2 healthy byte", status, 8'h00);
    chk("R6 output on", out_en, 1);

    below_lo = 1; step(); below_lo = 0;
    chk("R2 PNG at bit 4", status, 8'h10);
    chk("R8 PNG no irq", irq_n, 1);
    step(3);
    chk("R7 PNG holds in band", status, 8'h10);
    above_hi = 1; step(); above_hi = 0;
    chk("R7 PNG clears above 90%", status, 8'h00);

    oc_flag = 1; step(47); oc_flag = 0; step();
    chk("R3 47 cycles no trip", status, 8'h00);
    oc_flag = 1; step(47);
    chk("R3 count restarted", status, 8'h00);
    step();
    chk("R3 trip at 48th", status, 8'h05);
    chk("R5 output off", out_en, 0);
    chk("R8 irq on overcurrent", irq_n, 0);

    rd_ack9 = 1; step(); rd_ack9 = 0;
    chk("R4 OCP held while flag high", status, 8'h05);
    rd_addr = 1; step(); rd_addr = 0;
    chk("R9 released", irq_n, 1);
    oc_flag = 0; step();
    pulse_wr(1);
    chk("R6 write with fault latched", status, 8'h05);
    rd_ack9 = 1; step(); rd_ack9 = 0;
    chk("R4 OCP cleared", status, 8'h01);
    pulse_wr(1);
    chk("R6 re-enabled", out_en, 1);

    pulse_wr(0);
    chk("R6 disable write", status, 8'h01);
    chk("R8 DIS no irq", irq_n, 1);
    pulse_wr(1);

    ot_flag = 1; step(); ot_flag = 0;
    chk("R5 TSD sets DIS", status, 8'h41);
    chk("R8 irq on TSD", irq_n, 0);
    rd_addr = 1; uv_flag = 1; step(); rd_addr = 0; uv_flag = 0;
    chk("R9 new fault beats release", irq_n, 0);
    chk("R2 VUV at bit 7", status, 8'hC1);
    rd_ack9 = 1; step(); rd_ack9 = 0;
    pulse_wr(1);
    chk("R6 all cleared, enabled", status, 8'h00);
    step(2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule